// File: doc/BRIEF.md
# Per-CPU Device Interrupt Router

This block gathers up to 64 level-sensitive device interrupt lines into one shared raw request register and gives each of four processors its own filtered interrupt. Every processor owns a 64-bit enable mask. A processor's interrupt output is high while at least one raw request that its mask enables is pending. A separate input from a cascaded legacy interrupt controller is merged into a fixed raw bit, so legacy devices reach the processors through the same masking path.

Software reaches the block through a 64-bit register port. The port gives write and read access to the four masks. It also gives read-only access to the raw register and to four per-processor views, each holding that processor's mask ANDed with the raw register. Every request is answered exactly one clock later. A request to an offset that is not in the map gets an error response.

Top module: `irq_route_top`

## Requirements
- R1: The raw register bit n equals the level of `irq_in[n]` sampled at the previous rising clock edge. A read of the raw register at offset 0x300 returns it.
- R2: Raw bit 55 is the OR of `irq_in[55]` and `legacy_in`. The legacy input touches no other raw bit.
- R3: A write stores all 64 data bits into a processor's mask, and a read returns them. Processor 0 has its mask at offset 0x200, processor 1 at 0x240, processor 2 at 0x600 and processor 3 at 0x640.
- R4: A read of a processor's view returns that processor's mask AND the raw register. The views sit at the processor's mask offset plus 0x80 (0x280, 0x2C0, 0x680, 0x6C0).
- R5: `cpu_irq[i]` is high exactly when mask i AND raw is nonzero. After an input edge or a mask write, the output reflects the change at the next rising clock edge.
- R6: A write to a view or to the raw register gets a non-error response and changes no mask, no raw bit and no output.
- R7: A request to any offset outside the map gets `rsp_err` = 1 and `rsp_rdata` = 0. A write to such an offset changes no state. Offsets whose low three bits are nonzero are never in the map.
- R8: Every request accepted on `req_valid` gets exactly one `rsp_valid` pulse at the next rising edge. Write responses carry zero data.
- R9: After reset, all masks, the raw register, all outputs and `rsp_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Device interrupt levels, already synchronised |
| legacy_in | input | 1 | Cascaded legacy controller interrupt level |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Offset not decoded |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Level interrupt per processor |

## Verification
Each of the 64 input lines is raised alone while the four masks hold different patterns: all ones, alternate bits, the upper half only, and a single bit. A swapped bit, a wrong mask index or a missing AND therefore gives a wrong output on at least one processor. The legacy input is driven both alone and together with line 55, which separates an OR merge from an overwrite. Every 8-byte-aligned offset in the 4 KiB window is swept and compared with the map, along with a few misaligned offsets. Writes to the views and to the raw register are followed by read-back and output checks. Single-cycle samples taken just before and just after the edge pin down the one-cycle latency.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_VIEW = 2'd2,
        SEL_RAW  = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [1:0] cpu;
    } dec_t;

    localparam logic [ADDR_W-1:0] RAW_OFFSET  = 12'h300;
    localparam logic [ADDR_W-1:0] VIEW_DELTA  = 12'h080;
    localparam logic [ADDR_W-1:0] CPU_STRIDE  = 12'h040;
    localparam logic [ADDR_W-1:0] LOW_GROUP   = 12'h200;
    localparam logic [ADDR_W-1:0] HIGH_GROUP  = 12'h600;

    // Processors 0/1 live in the low group, 2/3 in the high group.
    function automatic logic [ADDR_W-1:0] mask_offset(input int c);
        logic [ADDR_W-1:0] idx;
        idx = ADDR_W'(c % 2);
        return ((c < 2) ? LOW_GROUP : HIGH_GROUP) + idx * CPU_STRIDE;
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.sel = SEL_NONE;
        dec.cpu = 2'd0;
        if (addr == RAW_OFFSET) begin
            dec.sel = SEL_RAW;
        end
        for (int c = 0; c < NUM_CPU; c++) begin
            if (addr == mask_offset(c)) begin
                dec.sel = SEL_MASK;
                dec.cpu = 2'(c);
            end
            if (addr == mask_offset(c) + VIEW_DELTA) begin
                dec.sel = SEL_VIEW;
                dec.cpu = 2'(c);
            end
        end
    end

endmodule

// File: rtl/irq_route_mask_bank.sv
module irq_route_mask_bank #(
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_cpu,
    input  logic [SRC_W-1:0]                wr_data,
    output logic [NUM_CPU-1:0][SRC_W-1:0]   mask_d,
    output logic [NUM_CPU-1:0][SRC_W-1:0]   mask_q
);

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        always_comb begin
            mask_d[g] = mask_q[g];
            if (wr_en && (wr_cpu == 2'(g))) begin
                mask_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[g] <= '0;
            end else begin
                mask_q[g] <= mask_d[g];
            end
        end
    end

endmodule

// File: rtl/irq_route_raw.sv
module irq_route_raw #(
    parameter int SRC_W      = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] irq_in,
    input  logic             legacy_in,
    output logic [SRC_W-1:0] raw_d,
    output logic [SRC_W-1:0] raw_q
);

    always_comb begin
        raw_d = irq_in;
        raw_d[LEGACY_BIT] = irq_in[LEGACY_BIT] | legacy_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= raw_d;
        end
    end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU    = 4,
    parameter int SRC_W      = 64,
    parameter int LEGACY_BIT = 55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SRC_W-1:0]   irq_in,
    input  logic               legacy_in,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [SRC_W-1:0]   req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [SRC_W-1:0]   rsp_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    typedef struct packed {
        logic [NUM_CPU-1:0] irq;
        logic               rv;
        logic               re;
        logic [SRC_W-1:0]   rd;
    } st_t;

    dec_t                          dec;
    logic                          mask_wr;
    logic [NUM_CPU-1:0][SRC_W-1:0] mask_d;
    logic [NUM_CPU-1:0][SRC_W-1:0] mask_q;
    logic [SRC_W-1:0]              raw_d;
    logic [SRC_W-1:0]              raw_q;
    st_t                           st_d;
    st_t                           st_q;

    irq_route_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    assign mask_wr = req_valid && req_write && (dec.sel == SEL_MASK);

    irq_route_mask_bank #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr),
        .wr_cpu  (dec.cpu),
        .wr_data (req_wdata),
        .mask_d  (mask_d),
        .mask_q  (mask_q)
    );

    irq_route_raw #(.SRC_W(SRC_W), .LEGACY_BIT(LEGACY_BIT)) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .legacy_in (legacy_in),
        .raw_d     (raw_d),
        .raw_q     (raw_q)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = req_valid;
        st_d.re = 1'b0;
        st_d.rd = '0;
        // Outputs follow next-state mask and raw so they stay aligned with the views.
        for (int c = 0; c < NUM_CPU; c++) begin
            st_d.irq[c] = |(mask_d[c] & raw_d);
        end
        if (req_valid) begin
            unique case (dec.sel)
                SEL_NONE: st_d.re = 1'b1;
                SEL_MASK: if (!req_write) st_d.rd = mask_q[dec.cpu];
                SEL_VIEW: if (!req_write) st_d.rd = mask_q[dec.cpu] & raw_q;
                SEL_RAW:  if (!req_write) st_d.rd = raw_q;
                default:  st_d.re = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_err   = st_q.re;
    assign rsp_rdata = st_q.rd;
    assign cpu_irq   = st_q.irq;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SRC_W-1:0]   irq_in,
    input logic               legacy_in,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_addr,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [SRC_W-1:0]   rsp_rdata,
    input logic [NUM_CPU-1:0] cpu_irq
);

    assert_rsp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_stray_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));

    assert_misaligned_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[2:0] != 3'b000)) |=> rsp_err);

    assert_idle_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_in == '0) && !legacy_in) |=> (cpu_irq == '0));

    assert_quiet_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(irq_in) && $stable(legacy_in) && !(req_valid && req_write))
        |=> $stable(cpu_irq));

endmodule

bind irq_route_top irq_route_chk #(.NUM_CPU(NUM_CPU), .SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .legacy_in (legacy_in),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .cpu_irq   (cpu_irq)
);

// File: tb/irq_route_top_test.sv
`timescale 1ns/1ps
module irq_route_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        legacy_in = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] mm [4];
    logic [63:0] raw_m;

    always #2.5 clk = ~clk;

    irq_route_top uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .legacy_in(legacy_in),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
    );

    function automatic logic [11:0] moff(input int c);
        return ((c < 2) ? 12'h200 : 12'h600) + 12'(c % 2) * 12'h040;
    endfunction

    function automatic bit in_map(input logic [11:0] a);
        if (a == 12'h300) return 1;
        for (int c = 0; c < 4; c++)
            if (a == moff(c) || a == moff(c) + 12'h080) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] exp_irq();
        logic [3:0] e;
        for (int c = 0; c < 4; c++) e[c] = |(mm[c] & raw_m);
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called one time unit after a rising edge; returns at the same phase.
    task automatic acc(input logic wr, input logic [11:0] a, input logic [63:0] d,
                       output logic [63:0] rd, output logic er);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        rd = rsp_rdata; er = rsp_err;
        chk(rsp_valid === 1'b1, "R8 rsp_valid", 64'(rsp_valid), 64'd1);
    endtask

    task automatic drive(input logic [63:0] v, input logic l);
        irq_in = v; legacy_in = l;
        raw_m = v; raw_m[55] = v[55] | l;
        @(posedge clk); #1;
    endtask

    task automatic wr_mask(input int c, input logic [63:0] v);
        logic [63:0] rd; logic er;
        acc(1'b1, moff(c), v, rd, er);
        mm[c] = v;
        chk(er === 1'b0 && rd === '0, "R8 write response", rd, 64'd0);
    endtask

    task automatic check_outputs(input string req);
        chk(cpu_irq === exp_irq(), req, 64'(cpu_irq), 64'(exp_irq()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic er;
        for (int c = 0; c < 4; c++) mm[c] = '0;
        raw_m = '0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R9: reset state
        chk(cpu_irq === 4'd0 && rsp_valid === 1'b0, "R9 outputs after reset",
            {59'd0, rsp_valid, cpu_irq}, 64'd0);
        acc(1'b0, 12'h300, '0, rd, er);
        chk(rd === '0 && !er, "R9 raw after reset", rd, 64'd0);
        for (int c = 0; c < 4; c++) begin
            acc(1'b0, moff(c), '0, rd, er);
            chk(rd === '0, "R9 mask after reset", rd, 64'd0);
        end

        // R3: mask write/read-back with distinct patterns
        wr_mask(0, 64'hFFFF_FFFF_FFFF_FFFF);
        wr_mask(1, 64'h5555_5555_5555_5555);
        wr_mask(2, 64'hFFFF_FFFF_0000_0000);
        wr_mask(3, 64'h0080_0000_0000_0000);
        for (int c = 0; c < 4; c++) begin
            acc(1'b0, moff(c), '0, rd, er);
            chk(rd === mm[c] && !er, "R3 mask read-back", rd, mm[c]);
        end

        // R1, R4, R5: each line alone
        for (int n = 0; n < 64; n++) begin
            drive(64'd1 << n, 1'b0);
            check_outputs("R5 single line");
            acc(1'b0, 12'h300, '0, rd, er);
            chk(rd === raw_m, "R1 raw read", rd, raw_m);
            acc(1'b0, moff(n % 4) + 12'h080, '0, rd, er);
            chk(rd === (mm[n % 4] & raw_m), "R4 view read", rd, mm[n % 4] & raw_m);
        end

        // R2: legacy input alone, then with line 55
        drive('0, 1'b1);
        check_outputs("R2 legacy alone");
        acc(1'b0, 12'h300, '0, rd, er);
        chk(rd === (64'd1 << 55), "R2 legacy raw bit", rd, 64'd1 << 55);
        drive(64'd1 << 55, 1'b1);
        acc(1'b0, 12'h300, '0, rd, er);
        chk(rd === (64'd1 << 55), "R2 legacy or line", rd, 64'd1 << 55);
        drive(64'd1 << 55, 1'b0);
        check_outputs("R2 line 55 keeps bit after legacy drops");
        drive('0, 1'b0);
        check_outputs("R5 all low");

        // R5: latency one cycle on input change
        wr_mask(1, 64'h0000_0000_0000_0002);
        irq_in = 64'd2; raw_m = 64'd2;
        #1 chk(cpu_irq === 4'd0, "R5 no change before edge", 64'(cpu_irq), 64'd0);
        @(posedge clk); #1;
        check_outputs("R5 one cycle after input");
        // R5: mask write deasserts on the next edge
        wr_mask(0, '0);
        check_outputs("R5 after mask write");
        wr_mask(1, '0);
        check_outputs("R5 mask clears irq");

        // R6: writes to read-only registers
        drive(64'hA5A5_0000_0000_00F0, 1'b0);
        wr_mask(2, 64'hFFFF_0000_0000_00FF);
        acc(1'b1, 12'h300, '1, rd, er);
        chk(!er, "R6 raw write response", 64'(er), 64'd0);
        acc(1'b1, 12'h680, '0, rd, er);
        chk(!er, "R6 view write response", 64'(er), 64'd0);
        acc(1'b0, 12'h300, '0, rd, er);
        chk(rd === raw_m, "R6 raw unchanged", rd, raw_m);
        acc(1'b0, 12'h600, '0, rd, er);
        chk(rd === mm[2], "R6 mask unchanged", rd, mm[2]);
        check_outputs("R6 outputs unchanged");

        // R7: sweep of aligned offsets, plus misaligned ones
        for (int a = 0; a < 4096; a += 8) begin
            acc(1'b0, 12'(a), '0, rd, er);
            if (in_map(12'(a)))
                chk(!er, "R7 mapped offset ok", 64'(er), 64'd0);
            else
                chk(er && rd === '0, "R7 undecoded error", {63'd0, er}, 64'd1);
        end
        acc(1'b0, 12'h204, '0, rd, er);
        chk(er === 1'b1, "R7 misaligned read", 64'(er), 64'd1);
        acc(1'b1, 12'h201, '1, rd, er);
        chk(er === 1'b1, "R7 misaligned write", 64'(er), 64'd1);
        acc(1'b1, 12'h208, '1, rd, er);
        chk(er === 1'b1, "R7 undecoded write", 64'(er), 64'd1);
        acc(1'b0, 12'h200, '0, rd, er);
        chk(rd === mm[0], "R7 write had no effect", rd, mm[0]);
        check_outputs("R7 outputs unchanged");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule